// File: doc/BRIEF.md
# Self-Programming Flash Control Unit

This unit sits beside a small processor core and handles two jobs. First, it lets software read back the fuse and lock bytes. A write to the control word with the enable and fuse-select bits set, and no operation bits, opens a short readback window. A program-memory load issued inside that window returns a configuration byte chosen by the low bits of the 16-bit pointer, in place of flash data. Once the window runs out, the control bits drop by themselves and loads return flash contents again.

Second, it sequences timed flash operations: page erase, page write and lock-bit write. Each operation starts from a single control write. A down-counter clocked by ticks from the internal oscillator times it, and a busy flag and a per-operation strobe to the flash array stay high until the count runs out. Control writes that arrive while busy are dropped. The ordinary reset does not stop an operation that is in progress. Only the power-on reset clears the timer.

Top module: `flash_selfprog_ctl`

## Requirements
- R1: Control word encoding is bit0 enable, bit1 erase, bit2 write, bit3 fuse-select. Writing enable and fuse-select with erase and write clear, while idle, opens a readback window. A load sampled in any of the three clock edges after the write returns a configuration byte, and `ctrl_stat` reads 4'b1001 while the window is open.
- R2: Inside the window, pointer 0x0000 returns the low fuse byte, 0x0001 the lock byte and 0x0003 the high fuse byte. Any pointer with a bit above bit 1 set returns 8'hFF.
- R3: Inside the window, pointer 0x0002 returns the extended fuse byte, with its 4 bits in positions 3:0 and positions 7:4 reading 1.
- R4: The configuration inputs flag programmed bits with 1. Readback returns each programmed bit as 0 and each unprogrammed bit as 1.
- R5: A load at the fourth edge after arming, or with no window open, returns `flash_rdata`. After the window expires, `ctrl_stat` returns to 0.
- R6: A load result appears on `lpm_data` with `lpm_valid` high in the cycle after the request edge. `lpm_valid` is low in cycles without a request.
- R7: Enable with erase starts a page erase, and erase wins when write is also set. Enable with write and no fuse-select starts a page write. Enable with write and fuse-select starts a lock write. Only the matching strobe is high. `ctrl_stat` bit1 shows an erase in progress, bit2 a page or lock write, and bit0 shows a window or an operation.
- R8: `busy` goes high after the start edge and drops at the edge that samples the WRITE_TICKS-th `osc_tick`. The operation strobe is high exactly while `busy` is high.
- R9: While `busy` is high, control writes have no effect. No window opens, and the running operation does not change.
- R10: Asserting `rst_n` closes the window and clears the load output but leaves a running operation to finish on its own ticks. Asserting `por_n` clears everything, the timer included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Ordinary active-low reset (window and load path) |
| por_n | input | 1 | Power-on active-low reset (whole unit, timer included) |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_data | input | 4 | Control word: enable, erase, write, fuse-select |
| osc_tick | input | 1 | One-cycle tick from the internal oscillator |
| lpm_req | input | 1 | Program-memory load request |
| z_ptr | input | 16 | Load pointer |
| flash_rdata | input | 8 | Byte read from the flash array at the pointer |
| fuse_lo_prog | input | 8 | Low fuse, 1 = programmed |
| fuse_hi_prog | input | 8 | High fuse, 1 = programmed |
| fuse_ext_prog | input | 4 | Extended fuse, 1 = programmed |
| lock_prog | input | 8 | Lock bits, 1 = programmed |
| lpm_data | output | 8 | Load result |
| lpm_valid | output | 1 | Load result valid |
| ctrl_stat | output | 4 | Control word readback |
| busy | output | 1 | Timed operation in progress |
| op_erase | output | 1 | Page erase strobe to the array |
| op_write | output | 1 | Page write strobe to the array |
| op_lock | output | 1 | Lock-bit write strobe to the array |

## Verification
The bench builds the unit with WRITE_TICKS set to 5 and the millisecond timing check switched off. Each erase, page write or lock write then completes in a handful of oscillator ticks, so the last-tick edge, reset arriving mid-operation and writes made while busy can all be reached many times in a short run. The window length stays at three cycles and the extended fuse at four bits, so the window's closing edge and the padding in bits 7:4 are exercised exactly as specified.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
   localparam int CTL_W     = 4;
   localparam int CTL_EN    = 0;
   localparam int CTL_ERASE = 1;
   localparam int CTL_WRITE = 2;
   localparam int CTL_FUSE  = 3;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_ERASE = 2'd1,
      OP_PAGE  = 2'd2,
      OP_LOCK  = 2'd3
   } fsp_op_e;
endpackage

// File: rtl/fsp_cmd_decode.sv
module fsp_cmd_decode
   import fsp_pkg::*;
(
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   input  logic             busy,
   input  logic             rst_n,
   output logic             arm,
   output logic             start,
   output fsp_op_e          op
);
   logic accept;

   always_comb begin
      accept = wr_en && rst_n && !busy && wr_data[CTL_EN];
      arm    = 1'b0;
      start  = 1'b0;
      op     = OP_NONE;
      if (accept) begin
         if (wr_data[CTL_ERASE]) begin
            start = 1'b1;
            op    = OP_ERASE;
         end else if (wr_data[CTL_WRITE]) begin
            start = 1'b1;
            op    = wr_data[CTL_FUSE] ? OP_LOCK : OP_PAGE;
         end else if (wr_data[CTL_FUSE]) begin
            arm = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fsp_write_timer.sv
module fsp_write_timer
   import fsp_pkg::*;
#(
   parameter int WRITE_TICKS    = 525,
   parameter int TICK_KHZ       = 128,
   parameter bit ENFORCE_TIMING = 1'b1
) (
   input  logic    clk,
   input  logic    por_n,
   input  logic    start,
   input  fsp_op_e start_op,
   input  logic    osc_tick,
   output logic    busy,
   output fsp_op_e run_op
);
   localparam int TICK_W = $clog2(WRITE_TICKS + 1);
   localparam logic [TICK_W-1:0] LOAD_VAL = TICK_W'(WRITE_TICKS);
   localparam int MIN_PROD = 3700 * TICK_KHZ;
   localparam int MAX_PROD = 4500 * TICK_KHZ;

   if (WRITE_TICKS < 1) begin : g_bad_ticks
      $error("WRITE_TICKS must be at least 1");
   end
   if (ENFORCE_TIMING) begin : g_timing
      if (WRITE_TICKS * 1000 < MIN_PROD || WRITE_TICKS * 1000 > MAX_PROD) begin : g_bad_time
         $error("WRITE_TICKS outside the 3.7 ms to 4.5 ms range");
      end
   end

   logic [TICK_W-1:0] cnt_q;
   fsp_op_e           op_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
         op_q  <= OP_NONE;
      end else if (start) begin
         cnt_q <= LOAD_VAL;
         op_q  <= start_op;
      end else if (osc_tick && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy   = (cnt_q != '0);
   assign run_op = busy ? op_q : OP_NONE;

   // R8
   busy_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(busy) |-> $past(osc_tick));
   // R8
   busy_rise_on_start_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(busy) |-> $past(start));
   // R9
   op_held_while_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
      $past(busy) |-> $stable(op_q));
endmodule

// File: rtl/fsp_fuse_window.sv
module fsp_fuse_window #(
   parameter int WIN_CYCLES = 3,
   parameter int PTR_W      = 16,
   parameter int EXT_BITS   = 4,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm,
   input  logic                lpm_req,
   input  logic [PTR_W-1:0]    z_ptr,
   input  logic [7:0]          flash_rdata,
   input  logic [7:0]          fuse_lo_prog,
   input  logic [7:0]          fuse_hi_prog,
   input  logic [EXT_BITS-1:0] fuse_ext_prog,
   input  logic [7:0]          lock_prog,
   output logic                win_open,
   output logic [7:0]          lpm_data,
   output logic                lpm_valid
);
   localparam int WIN_W = $clog2(WIN_CYCLES + 1);
   localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CYCLES);

   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("WIN_CYCLES must be at least 1");
   end
   if (PTR_W < 3) begin : g_bad_ptr
      $error("PTR_W must be at least 3");
   end
   if (EXT_BITS < 1 || EXT_BITS > 8) begin : g_bad_ext
      $error("EXT_BITS must be between 1 and 8");
   end

   logic [WIN_W-1:0] win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else if (arm) win_q <= WIN_LOAD;
      else if (win_q != '0) win_q <= win_q - 1'b1;
   end

   assign win_open = (win_q != '0);

   logic [7:0] ext_byte;
   if (EXT_BITS == 8) begin : g_ext_full
      assign ext_byte = ~fuse_ext_prog;
   end else begin : g_ext_pad
      assign ext_byte = {{(8 - EXT_BITS){1'b1}}, ~fuse_ext_prog};
   end

   logic [7:0] cfg_byte;
   logic [7:0] sel_byte;

   always_comb begin
      if (|z_ptr[PTR_W-1:2]) begin
         cfg_byte = 8'hFF;
      end else begin
         case (z_ptr[1:0])
            2'd0:    cfg_byte = ~fuse_lo_prog;
            2'd1:    cfg_byte = ~lock_prog;
            2'd2:    cfg_byte = ext_byte;
            default: cfg_byte = ~fuse_hi_prog;
         endcase
      end
      sel_byte = win_open ? cfg_byte : flash_rdata;
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lpm_data  <= '0;
            lpm_valid <= 1'b0;
         end else begin
            lpm_valid <= lpm_req;
            if (lpm_req) lpm_data <= sel_byte;
         end
      end

      // R6
      valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lpm_valid |-> $past(lpm_req));
   end else begin : g_out_comb
      assign lpm_data  = sel_byte;
      assign lpm_valid = lpm_req;
   end

   // R1
   win_opens_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(arm));
   // R5
   win_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && !arm && win_q == WIN_W'(1)) |=> !win_open);
endmodule

// File: rtl/flash_selfprog_ctl.sv
module flash_selfprog_ctl
   import fsp_pkg::*;
#(
   parameter int WRITE_TICKS    = 525,
   parameter int TICK_KHZ       = 128,
   parameter bit ENFORCE_TIMING = 1'b1,
   parameter int WIN_CYCLES     = 3,
   parameter int PTR_W          = 16,
   parameter int EXT_BITS       = 4,
   parameter bit OUT_REG        = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                por_n,
   input  logic                ctrl_wr_en,
   input  logic [CTL_W-1:0]    ctrl_wr_data,
   input  logic                osc_tick,
   input  logic                lpm_req,
   input  logic [PTR_W-1:0]    z_ptr,
   input  logic [7:0]          flash_rdata,
   input  logic [7:0]          fuse_lo_prog,
   input  logic [7:0]          fuse_hi_prog,
   input  logic [EXT_BITS-1:0] fuse_ext_prog,
   input  logic [7:0]          lock_prog,
   output logic [7:0]          lpm_data,
   output logic                lpm_valid,
   output logic [CTL_W-1:0]    ctrl_stat,
   output logic                busy,
   output logic                op_erase,
   output logic                op_write,
   output logic                op_lock
);
   logic    arm;
   logic    start;
   fsp_op_e start_op;
   fsp_op_e run_op;
   logic    win_open;
   logic    win_rst_n;

   assign win_rst_n = rst_n & por_n;

   fsp_cmd_decode u_decode (
      .wr_en   (ctrl_wr_en),
      .wr_data (ctrl_wr_data),
      .busy    (busy),
      .rst_n   (win_rst_n),
      .arm     (arm),
      .start   (start),
      .op      (start_op)
   );

   fsp_write_timer #(
      .WRITE_TICKS    (WRITE_TICKS),
      .TICK_KHZ       (TICK_KHZ),
      .ENFORCE_TIMING (ENFORCE_TIMING)
   ) u_timer (
      .clk      (clk),
      .por_n    (por_n),
      .start    (start),
      .start_op (start_op),
      .osc_tick (osc_tick),
      .busy     (busy),
      .run_op   (run_op)
   );

   fsp_fuse_window #(
      .WIN_CYCLES (WIN_CYCLES),
      .PTR_W      (PTR_W),
      .EXT_BITS   (EXT_BITS),
      .OUT_REG    (OUT_REG)
   ) u_window (
      .clk           (clk),
      .rst_n         (win_rst_n),
      .arm           (arm),
      .lpm_req       (lpm_req),
      .z_ptr         (z_ptr),
      .flash_rdata   (flash_rdata),
      .fuse_lo_prog  (fuse_lo_prog),
      .fuse_hi_prog  (fuse_hi_prog),
      .fuse_ext_prog (fuse_ext_prog),
      .lock_prog     (lock_prog),
      .win_open      (win_open),
      .lpm_data      (lpm_data),
      .lpm_valid     (lpm_valid)
   );

   assign op_erase = (run_op == OP_ERASE);
   assign op_write = (run_op == OP_PAGE);
   assign op_lock  = (run_op == OP_LOCK);

   always_comb begin
      ctrl_stat            = '0;
      ctrl_stat[CTL_EN]    = win_open | busy;
      ctrl_stat[CTL_ERASE] = op_erase;
      ctrl_stat[CTL_WRITE] = op_write | op_lock;
      ctrl_stat[CTL_FUSE]  = win_open | op_lock;
   end

   // R7
   one_strobe_chk: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0({op_erase, op_write, op_lock}));
   // R8
   strobe_matches_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
      busy == (op_erase | op_write | op_lock));
   // R10
   op_survives_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
      (busy && !osc_tick) |=> busy);
   // R9
   no_window_while_busy_chk: assert property (@(posedge clk) disable iff (!win_rst_n)
      ($past(busy) && !$past(win_open)) |-> !win_open);
endmodule

// File: tb/flash_selfprog_ctl_tb_top.sv
module flash_selfprog_ctl_tb_top;
   localparam int TICKS = 5;
   localparam logic [3:0] C_ARM   = 4'b1001;
   localparam logic [3:0] C_ERASE = 4'b0011;
   localparam logic [3:0] C_BOTH  = 4'b0111;
   localparam logic [3:0] C_PAGE  = 4'b0101;
   localparam logic [3:0] C_LOCK  = 4'b1101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0, por_n = 1'b0;
   logic        ctrl_wr_en = 1'b0;
   logic [3:0]  ctrl_wr_data = '0;
   logic        osc_tick = 1'b0, lpm_req = 1'b0;
   logic [15:0] z_ptr = '0;
   logic [7:0]  flash_rdata = 8'h3C;
   logic [7:0]  fuse_lo_prog = '0, fuse_hi_prog = '0, lock_prog = '0;
   logic [3:0]  fuse_ext_prog = '0;
   logic [7:0]  lpm_data;
   logic        lpm_valid;
   logic [3:0]  ctrl_stat;
   logic        busy, op_erase, op_write, op_lock;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   flash_selfprog_ctl #(
      .WRITE_TICKS(TICKS), .TICK_KHZ(1), .ENFORCE_TIMING(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .ctrl_wr_en(ctrl_wr_en),
      .ctrl_wr_data(ctrl_wr_data), .osc_tick(osc_tick), .lpm_req(lpm_req),
      .z_ptr(z_ptr), .flash_rdata(flash_rdata), .fuse_lo_prog(fuse_lo_prog),
      .fuse_hi_prog(fuse_hi_prog), .fuse_ext_prog(fuse_ext_prog),
      .lock_prog(lock_prog), .lpm_data(lpm_data), .lpm_valid(lpm_valid),
      .ctrl_stat(ctrl_stat), .busy(busy), .op_erase(op_erase),
      .op_write(op_write), .op_lock(op_lock)
   );

   function automatic logic [7:0] exp_load(logic [15:0] p, bit in_win);
      if (!in_win) return flash_rdata;
      if (|p[15:2]) return 8'hFF;
      case (p[1:0])
         2'd0:    return ~fuse_lo_prog;
         2'd1:    return ~lock_prog;
         2'd2:    return {4'hF, ~fuse_ext_prog};
         default: return ~fuse_hi_prog;
      endcase
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ctrl_write(logic [3:0] d);
      ctrl_wr_en = 1'b1;
      ctrl_wr_data = d;
      @(negedge clk);
      ctrl_wr_en = 1'b0;
      ctrl_wr_data = '0;
   endtask

   task automatic load(logic [15:0] p, output logic [7:0] q, output logic v);
      lpm_req = 1'b1;
      z_ptr = p;
      @(negedge clk);
      lpm_req = 1'b0;
      q = lpm_data;
      v = lpm_valid;
   endtask

   task automatic tick_n(int n);
      repeat (n) begin
         osc_tick = 1'b1;
         @(negedge clk);
         osc_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] q;
      logic v;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R5 reset stat", {4'h0, ctrl_stat}, 8'h00);
      check("R8 reset busy", {7'h0, busy}, 8'h00);
      check("R6 reset valid", {7'h0, lpm_valid}, 8'h00);

      fuse_lo_prog = 8'h62; fuse_hi_prog = 8'hD9; lock_prog = 8'h3C;
      fuse_ext_prog = 4'h5; flash_rdata = 8'hA7;

      // no window: flash data
      load(16'h0002, q, v);
      check("R5 no window data", q, 8'hA7);
      check("R6 valid after req", {7'h0, v}, 8'h01);
      @(negedge clk);
      check("R6 valid low idle", {7'h0, lpm_valid}, 8'h00);

      // R1 R3 arm and read extended fuse
      ctrl_write(C_ARM);
      check("R1 stat open", {4'h0, ctrl_stat}, 8'h09);
      load(16'h0002, q, v);
      check("R3 ext fuse", q, 8'hFA);
      repeat (4) @(negedge clk);

      // R1 last edge of window
      ctrl_write(C_ARM);
      repeat (2) @(negedge clk);
      load(16'h0000, q, v);
      check("R1 third edge", q, 8'h9D);
      repeat (4) @(negedge clk);

      // R5 expired window
      ctrl_write(C_ARM);
      repeat (3) @(negedge clk);
      check("R5 stat cleared", {4'h0, ctrl_stat}, 8'h00);
      load(16'h0001, q, v);
      check("R5 after window", q, 8'hA7);

      // R2 pointer decode
      ctrl_write(C_ARM);
      load(16'h0001, q, v);
      check("R2 lock byte", q, 8'hC3);
      load(16'h0003, q, v);
      check("R2 high fuse", q, 8'h26);
      repeat (4) @(negedge clk);
      ctrl_write(C_ARM);
      load(16'h0100, q, v);
      check("R2 out of range", q, 8'hFF);
      repeat (4) @(negedge clk);

      // R4 all programmed / none programmed
      fuse_lo_prog = 8'hFF; fuse_ext_prog = 4'hF;
      ctrl_write(C_ARM);
      load(16'h0000, q, v);
      check("R4 all programmed", q, 8'h00);
      load(16'h0002, q, v);
      check("R4 ext programmed", q, 8'hF0);
      repeat (4) @(negedge clk);
      fuse_hi_prog = 8'h00;
      ctrl_write(C_ARM);
      load(16'h0003, q, v);
      check("R4 none programmed", q, 8'hFF);
      repeat (4) @(negedge clk);

      // R7 erase, R9 ignored writes, R8 timing
      ctrl_write(C_ERASE);
      check("R7 erase stat", {4'h0, ctrl_stat}, 8'h03);
      check("R7 erase strobes", {5'h0, op_lock, op_write, op_erase}, 8'h01);
      ctrl_write(C_ARM);
      check("R9 arm ignored stat", {4'h0, ctrl_stat}, 8'h03);
      load(16'h0000, q, v);
      check("R9 arm ignored load", q, 8'hA7);
      ctrl_write(C_PAGE);
      check("R9 op unchanged", {5'h0, op_lock, op_write, op_erase}, 8'h01);
      tick_n(TICKS - 1);
      check("R8 busy before last tick", {7'h0, busy}, 8'h01);
      tick_n(1);
      check("R8 busy after last tick", {7'h0, busy}, 8'h00);
      check("R8 strobe off", {5'h0, op_lock, op_write, op_erase}, 8'h00);

      // R7 erase priority
      ctrl_write(C_BOTH);
      check("R7 erase priority", {5'h0, op_lock, op_write, op_erase}, 8'h01);
      tick_n(TICKS);

      // R7 page write
      ctrl_write(C_PAGE);
      check("R7 page stat", {4'h0, ctrl_stat}, 8'h05);
      check("R7 page strobe", {5'h0, op_lock, op_write, op_erase}, 8'h02);
      tick_n(TICKS);

      // R7 lock write
      ctrl_write(C_LOCK);
      check("R7 lock stat", {4'h0, ctrl_stat}, 8'h0D);
      check("R7 lock strobe", {5'h0, op_lock, op_write, op_erase}, 8'h04);
      tick_n(TICKS);
      check("R8 lock done", {7'h0, busy}, 8'h00);

      // R10 reset during operation
      ctrl_write(C_PAGE);
      rst_n = 1'b0;
      tick_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 op survives reset", {6'h0, busy, op_write}, 8'h03);
      tick_n(TICKS - 3);
      check("R10 op finishes", {7'h0, busy}, 8'h00);

      // R10 reset closes window
      ctrl_write(C_ARM);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R10 window closed stat", {4'h0, ctrl_stat}, 8'h00);
      load(16'h0000, q, v);
      check("R10 window closed load", q, 8'hA7);

      // R10 power-on reset clears timer
      ctrl_write(C_ERASE);
      por_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      check("R10 por clears op", {6'h0, busy, op_erase}, 8'h00);

      // random readback R1 R2 R3 R4 R5
      for (int i = 0; i < 60; i++) begin
         int d;
         logic [15:0] p;
         fuse_lo_prog = 8'($urandom);
         fuse_hi_prog = 8'($urandom);
         lock_prog = 8'($urandom);
         fuse_ext_prog = 4'($urandom);
         flash_rdata = 8'($urandom);
         d = int'($urandom_range(0, 4));
         p = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'($urandom_range(0, 3));
         ctrl_write(C_ARM);
         repeat (d) @(negedge clk);
         load(p, q, v);
         check("R1 R2 R3 R4 R5 random", q, exp_load(p, d < 3));
         repeat (4) @(negedge clk);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule